// File: doc/BRIEF.md
# Tick Compare Timer Interrupt Unit

This block keeps two free-running 63-bit counters, a tick counter and a system-tick counter, each with its own count enable. It also holds three 64-bit compare registers. Software loads a compare register through a single write port and can read any compare register back through a read port. The top bit of a compare register is an interrupt-disable flag, and the low 63 bits hold a target count.

The block decides whether to arm a compare register only at the moment that register is written. The register is armed when its disable flag is clear and its target lies strictly ahead of the counter it watches. An armed register waits until its counter reaches the target exactly. It then raises its own interrupt line for one cycle and disarms itself. Rewriting a register always drops any earlier arming of that register. A register written with a target at or behind its counter stays silent until it is written again.

Slot 0 watches the tick counter. Slots 1 (supervisor) and 2 (hypervisor) both watch the system-tick counter.

Top module: `tcmp_unit`

## Requirements
- R1: While reset is high, every compare register reads back 0x8000_0000_0000_0000 (disable set, target zero). Both counters read 0, all interrupt lines are low, and no slot is armed.
- R2: Each counter increases by exactly one on every clock edge where its enable is high, and holds its value on every edge where its enable is low.
- R3: Selector value 0 addresses the tick-compare slot, which watches the tick counter. Value 1 addresses the supervisor slot and value 2 the hypervisor slot, and both of these watch the system-tick counter. A write with selector 3 changes nothing, and a read with selector 3 returns zero.
- R4: Reading a compare register returns the full 64-bit value last written to it, including bit 63.
- R5: A write arms its slot only when bit 63 of the written value is 0 and bits 62:0 are strictly greater than the watched counter's value in the write cycle.
- R6: An armed slot raises its interrupt line for exactly one cycle. The pulse appears in the cycle after the edge at which the watched counter equals the target. The slot then disarms, so the interrupt does not repeat.
- R7: A slot written with bit 63 set, or with a target equal to or below its counter, never raises its interrupt until it is rewritten.
- R8: Writing a slot cancels any earlier arming of that slot. If the write lands on the same edge at which a match would fire, the write wins and no pulse is produced.
- R9: An armed slot whose counter is paused does not fire. It fires once counting resumes and the counter reaches the target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Tick counter advance enable |
| stick_en | input | 1 | System-tick counter advance enable |
| wr_en | input | 1 | Compare register write strobe |
| wr_sel | input | 2 | Slot selector for writes |
| wr_data | input | 64 | Write value: bit 63 disable, bits 62:0 target |
| rd_sel | input | 2 | Slot selector for reads |
| rd_data | output | 64 | Read value of the selected slot |
| tick_cnt | output | 63 | Current tick counter value |
| stick_cnt | output | 63 | Current system-tick counter value |
| irq | output | 3 | Per-slot one-cycle interrupt pulses (bit index = slot) |

## Verification
The bench writes targets one ahead of the counter, several ahead, equal to the counter, behind it, and ahead but with the disable flag set. A design that used greater-or-equal for arming, or that ignored the flag, would pulse where silence is expected. A design that did not disarm after a match would pulse a second time. To check cancellation, a rewrite is placed exactly on the edge where a match would fire; a design that gave the match priority would leak one pulse. Pausing the system-tick counter while the tick counter runs separates the slots by counter source. A miswired slot would then fire early or never.

// File: rtl/tcmp_pkg.sv
package tcmp_pkg;

    localparam int unsigned CNT_W   = 63;
    localparam int unsigned REG_W   = CNT_W + 1;
    localparam int unsigned NUM_CMP = 3;
    localparam int unsigned SEL_W   = $clog2(NUM_CMP + 1);

    typedef enum logic {
        SRC_TICK  = 1'b0,
        SRC_STICK = 1'b1
    } cnt_src_e;

    typedef struct packed {
        logic             dis;
        logic [CNT_W-1:0] target;
    } cmp_reg_t;

    localparam cmp_reg_t CMP_RESET = '{dis: 1'b1, target: '0};

    // slot 0 follows the tick counter, the others the system tick
    function automatic cnt_src_e slot_src(input int unsigned idx);
        return (idx == 0) ? SRC_TICK : SRC_STICK;
    endfunction

    function automatic logic arm_ok(input cmp_reg_t v, input logic [CNT_W-1:0] cnt);
        return !v.dis && (v.target > cnt);
    endfunction

endpackage

// File: rtl/tcmp_counter.sv
module tcmp_counter
    import tcmp_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    output logic [CNT_W-1:0] cnt
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (en) begin
            cnt <= cnt + 1'b1;
        end
    end

    a_r2_step: assert property (@(posedge clk) disable iff (rst)
        en |=> (cnt == $past(cnt) + 1'b1));

    a_r2_hold: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(cnt));

endmodule

// File: rtl/tcmp_slot.sv
module tcmp_slot
    import tcmp_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_i,
    input  cmp_reg_t         wr_data_i,
    input  logic [CNT_W-1:0] cnt_i,
    output cmp_reg_t         value_o,
    output logic             irq_o
);

    cmp_reg_t reg_q;
    logic     armed_q;
    logic     irq_q;
    logic     hit;

    assign hit = armed_q && (cnt_i == reg_q.target);

    always_ff @(posedge clk) begin
        if (rst) begin
            reg_q   <= CMP_RESET;
            armed_q <= 1'b0;
            irq_q   <= 1'b0;
        end else begin
            irq_q <= 1'b0;
            if (wr_i) begin
                reg_q   <= wr_data_i;
                armed_q <= arm_ok(wr_data_i, cnt_i);
            end else if (hit) begin
                armed_q <= 1'b0;
                irq_q   <= 1'b1;
            end
        end
    end

    assign value_o = reg_q;
    assign irq_o   = irq_q;

    a_r6_single_pulse: assert property (@(posedge clk) disable iff (rst)
        irq_q |=> !irq_q);

    a_r6_disarm_after_fire: assert property (@(posedge clk) disable iff (rst)
        irq_q |-> !armed_q);

    a_r7_no_arm_disabled: assert property (@(posedge clk) disable iff (rst)
        (wr_i && wr_data_i.dis) |=> !armed_q);

    a_r7_no_arm_behind: assert property (@(posedge clk) disable iff (rst)
        (wr_i && (wr_data_i.target <= cnt_i)) |=> !armed_q);

    a_r8_write_blocks_irq: assert property (@(posedge clk) disable iff (rst)
        wr_i |=> !irq_q);

    a_r4_holds_written: assert property (@(posedge clk) disable iff (rst)
        wr_i |=> (reg_q == $past(wr_data_i)));

endmodule

// File: rtl/tcmp_unit.sv
module tcmp_unit
    import tcmp_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_en,
    input  logic             stick_en,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] wr_sel,
    input  logic [REG_W-1:0] wr_data,
    input  logic [SEL_W-1:0] rd_sel,
    output logic [REG_W-1:0] rd_data,
    output logic [CNT_W-1:0] tick_cnt,
    output logic [CNT_W-1:0] stick_cnt,
    output logic [NUM_CMP-1:0] irq
);

    cmp_reg_t vals [NUM_CMP];

    tcmp_counter u_tick (
        .clk (clk),
        .rst (rst),
        .en  (tick_en),
        .cnt (tick_cnt)
    );

    tcmp_counter u_stick (
        .clk (clk),
        .rst (rst),
        .en  (stick_en),
        .cnt (stick_cnt)
    );

    for (genvar i = 0; i < NUM_CMP; i++) begin : g_slot
        localparam cnt_src_e SRC = slot_src(i);
        logic [CNT_W-1:0] cnt_sel;
        logic             wr_hit;

        if (SRC == SRC_TICK) begin : g_tick
            assign cnt_sel = tick_cnt;
        end else begin : g_stick
            assign cnt_sel = stick_cnt;
        end

        assign wr_hit = wr_en && (wr_sel == SEL_W'(i));

        tcmp_slot u_slot (
            .clk       (clk),
            .rst       (rst),
            .wr_i      (wr_hit),
            .wr_data_i (cmp_reg_t'(wr_data)),
            .cnt_i     (cnt_sel),
            .value_o   (vals[i]),
            .irq_o     (irq[i])
        );
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM_CMP; i++) begin
            if (rd_sel == SEL_W'(i)) rd_data = vals[i];
        end
    end

    a_r1_quiet_in_reset: assert property (@(posedge clk)
        rst |=> (irq == '0));

    a_r9_paused_no_fire: assert property (@(posedge clk) disable iff (rst)
        (!stick_en && $past(!stick_en) && $past(!stick_en, 2) && !$past(wr_en) && !$past(wr_en, 2))
            |-> (irq[NUM_CMP-1:1] == '0));

endmodule

// File: tb/tcmp_unit_tb.sv
`timescale 1ns/1ps
module tcmp_unit_tb;
    import tcmp_pkg::*;

    logic             clk = 1'b0;
    logic             rst;
    logic             tick_en, stick_en, wr_en;
    logic [SEL_W-1:0] wr_sel, rd_sel;
    logic [REG_W-1:0] wr_data, rd_data;
    logic [CNT_W-1:0] tick_cnt, stick_cnt;
    logic [NUM_CMP-1:0] irq;

    int checks = 0;
    int errors = 0;
    logic done = 1'b0;

    always #2.5 clk = ~clk;

    tcmp_unit u_dut (
        .clk(clk), .rst(rst), .tick_en(tick_en), .stick_en(stick_en),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .rd_sel(rd_sel),
        .rd_data(rd_data), .tick_cnt(tick_cnt), .stick_cnt(stick_cnt), .irq(irq)
    );

    typedef struct packed {
        logic [1:0]        sel;
        logic              dis;
        logic signed [7:0] delta;
        logic              fire;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 1'b0,  8'sd1, 1'b1},
        '{2'd1, 1'b0,  8'sd3, 1'b1},
        '{2'd2, 1'b0,  8'sd6, 1'b1},
        '{2'd0, 1'b0,  8'sd0, 1'b0},
        '{2'd1, 1'b0, -8'sd2, 1'b0},
        '{2'd2, 1'b1,  8'sd4, 1'b0},
        '{2'd1, 1'b0,  8'sd2, 1'b1},
        '{2'd2, 1'b0,  8'sd0, 1'b0}
    };

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic write_slot(input logic [1:0] sel, input logic dis, input logic [CNT_W-1:0] tgt);
        wr_en   = 1'b1;
        wr_sel  = sel;
        wr_data = {dis, tgt};
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic run_vec(input vec_t v);
        logic [CNT_W-1:0] c;
        logic [CNT_W-1:0] tgt;
        logic             ok;
        @(negedge clk);
        c   = (v.sel == 2'd0) ? tick_cnt : stick_cnt;
        tgt = c + CNT_W'(signed'(v.delta));
        write_slot(v.sel, v.dis, tgt);
        ok = 1'b1;
        for (int n = 1; n <= 12; n++) begin
            logic [NUM_CMP-1:0] exp_irq;
            exp_irq = '0;
            if (v.fire && n == int'(v.delta) + 1) exp_irq[v.sel] = 1'b1;
            if (irq !== exp_irq) begin
                ok = 1'b0;
                chk(v.fire ? "R6 pulse timing" : "R7 no pulse", 64'(irq), 64'(exp_irq));
            end
            @(negedge clk);
        end
        if (ok) chk(v.fire ? "R5 R6 armed pulse" : "R7 silent slot", 64'(irq), 64'(irq));
        rd_sel = v.sel;
        #1;
        chk("R4 readback", rd_data, {v.dis, tgt});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [CNT_W-1:0] c0, s0;
        int p0, p1, wait_n;
        rst = 1'b1; tick_en = 1'b1; stick_en = 1'b1; wr_en = 1'b0;
        wr_sel = '0; wr_data = '0; rd_sel = '0;
        repeat (4) @(negedge clk);
        // R1 reset state with counters enabled
        chk("R1 tick", 64'(tick_cnt), 64'd0);
        chk("R1 stick", 64'(stick_cnt), 64'd0);
        chk("R1 irq", 64'(irq), 64'd0);
        for (int s = 0; s < 3; s++) begin
            rd_sel = 2'(s);
            #1;
            chk("R1 compare reset", rd_data, 64'h8000_0000_0000_0000);
        end
        rst = 1'b0;
        repeat (3) @(negedge clk);

        // R2 counting and holding
        c0 = tick_cnt; s0 = stick_cnt;
        stick_en = 1'b0;
        repeat (5) @(negedge clk);
        chk("R2 tick advances", 64'(tick_cnt), 64'(c0 + 5));
        chk("R2 stick holds", 64'(stick_cnt), 64'(s0));
        stick_en = 1'b1;
        repeat (4) @(negedge clk);
        chk("R2 stick resumes", 64'(stick_cnt), 64'(s0 + 4));

        // table of vectors
        for (int i = 0; i < NV; i++) run_vec(VECS[i]);

        // R3 selector 3 ignored and reads zero
        rd_sel = 2'd0; #1; c0 = rd_data[CNT_W-1:0];
        write_slot(2'd3, 1'b0, tick_cnt + 2);
        rd_sel = 2'd3; #1;
        chk("R3 sel3 reads zero", rd_data, 64'd0);
        rd_sel = 2'd0; #1;
        chk("R3 sel3 write ignored", 64'(rd_data[CNT_W-1:0]), 64'(c0));
        repeat (6) begin
            chk("R3 sel3 no irq", 64'(irq), 64'd0);
            @(negedge clk);
        end

        // R3 / R9 source mapping with system tick paused
        stick_en = 1'b0;
        @(negedge clk);
        write_slot(2'd1, 1'b0, stick_cnt + 2);
        write_slot(2'd0, 1'b0, tick_cnt + 3);
        p0 = 0; p1 = 0;
        for (int n = 0; n < 10; n++) begin
            if (irq[0]) p0++;
            if (irq[1]) p1++;
            @(negedge clk);
        end
        chk("R3 tick slot fires once", 64'(p0), 64'd1);
        chk("R9 paused slot silent", 64'(p1), 64'd0);
        stick_en = 1'b1;
        wait_n = 0;
        for (int n = 1; n <= 8; n++) begin
            @(negedge clk);
            if (irq[1] && wait_n == 0) wait_n = n;
        end
        chk("R9 fires after resume", 64'(wait_n), 64'd3);

        // R8 rewrite with disable cancels
        write_slot(2'd2, 1'b0, stick_cnt + 4);
        write_slot(2'd2, 1'b1, stick_cnt + 4);
        p0 = 0;
        repeat (10) begin
            if (irq[2]) p0++;
            @(negedge clk);
        end
        chk("R8 rewrite cancels", 64'(p0), 64'd0);

        // R8 rewrite on the exact match edge wins
        write_slot(2'd2, 1'b0, stick_cnt + 2);
        @(negedge clk);
        write_slot(2'd2, 1'b1, '0);
        p0 = 0;
        repeat (8) begin
            if (irq[2]) p0++;
            @(negedge clk);
        end
        chk("R8 write beats match", 64'(p0), 64'd0);

        // R6 no repeat after a pulse
        write_slot(2'd1, 1'b0, stick_cnt + 1);
        p0 = 0;
        repeat (12) begin
            if (irq[1]) p0++;
            @(negedge clk);
        end
        chk("R6 single pulse", 64'(p0), 64'd1);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule